// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Error Retry

This block sends one character on the open-drain, half-duplex I/O line of a smart card. A strobe captures a data byte and a coding-convention flag. The block then drives a low start bit, eight data bits and a parity bit. Each bit lasts one elementary time unit (ETU), which is a fixed number of card clock cycles. The card clock is supplied to the block as a one-cycle enable on the system clock.

After the parity bit the block releases the line for one guard ETU and samples it at the end of that ETU. A low level there means the receiver is reporting a parity error. In that case the block keeps the line released for two ETUs and sends the same character again, up to a bounded number of times. At the end it pulses `done_o` and reports the result on `fail_o`.

The block refuses a request when the card clock or the card is absent. It then drives nothing and reports a failure at once. It is meant to sit under a protocol engine that hands it one byte at a time and waits for `done_o`.

Top module: `sc_char_tx`

## Requirements
- R1: Out of reset, `drive_low_o`, `busy_o`, `done_o` and `fail_o` are all 0.
- R2: Each bit is held for exactly `ETU_CYCLES` cycles in which `card_tick_i` is 1. Cycles with `card_tick_i` at 0 do not advance the bit timing.
- R3: In the direct convention (`inverse_i`=0), the line shows, in order: a start bit at level 0, then `data_i[0]` up to `data_i[7]`, then a parity level equal to the XOR of the eight data bits. Level 0 means `drive_low_o`=1 and level 1 means released.
- R4: In the inverse convention (`inverse_i`=1), the line shows, in order: a start bit at level 0, then the complement of `data_i[7]` down to `data_i[0]`, then a parity level equal to the complement of the XOR of the eight data bits.
- R5: After the parity bit the line is released for one guard ETU. `io_i` is sampled on the last card tick of that ETU. If it is high, `done_o` follows in the next cycle with `fail_o`=0.
- R6: If `io_i` is low at that sample, the line stays released for two more ETUs. The identical ten-bit frame is then sent again.
- R7: At most `MAX_RETRY` (default 4) resends are made. If the sample after the last resend is still low, `done_o` is raised with `fail_o`=1. Exactly `MAX_RETRY` errors followed by a clean sample ends with `fail_o`=0.
- R8: A strobe that arrives while `clk_present_i` or `card_present_i` is 0 drives no bit. `done_o` is raised in the next cycle with `fail_o`=1. The line is never driven while `busy_o` is 0.
- R9: A strobe that arrives while `busy_o` is 1 is ignored, along with any new `data_i` or `inverse_i` values. The frame in flight is unchanged.
- R10: `busy_o` is 1 from the cycle after an accepted or refused strobe through the `done_o` cycle. `done_o` is a single-cycle pulse. `fail_o` keeps its value from one `done_o` until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| card_tick_i | input | 1 | One-cycle enable per card clock cycle |
| clk_present_i | input | 1 | Card clock is running |
| card_present_i | input | 1 | Card is inserted |
| start_i | input | 1 | Transmit request strobe |
| data_i | input | 8 | Character to send |
| inverse_i | input | 1 | 1 selects inverse convention |
| io_i | input | 1 | Sensed level of the shared I/O line |
| drive_low_o | output | 1 | Open-drain enable: 1 pulls the line low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| fail_o | output | 1 | Result of the last transfer (1 = failed or refused) |

## Verification
The bench targets the retry boundary: exactly four receiver errors must still end in success, and a fifth must end in failure. A counter off by one would flip `fail_o` or add a thirteen-ETU attempt. It also sends characters in the inverse convention, where a missing bit reversal or a wrong parity polarity shows up as a wrong line level in a single ETU. It gates the card tick to one cycle in three, which exposes an ETU counter that runs on the system clock. Finally, it pulses the strobe with new data in the middle of a frame: a design that re-latches the inputs would change the bits on the line.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int FRAME_BITS   = 10;
  localparam int SLOT_W       = $clog2(FRAME_BITS);
  localparam int BACKOFF_ETUS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_GUARD,
    ST_BACKOFF,
    ST_DONE
  } tx_state_e;
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int ETU_CYCLES = 372
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic etu_end_o
);
  localparam int CW = (ETU_CYCLES > 1) ? $clog2(ETU_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(ETU_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i)             cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign etu_end_o = tick_i && !clr_i && (cnt_q == LAST);

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_tick_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sc_frame_build.sv
module sc_frame_build
  import sc_tx_pkg::*;
(
  input  logic                  inverse_i,
  input  logic [7:0]            data_i,
  output logic [FRAME_BITS-1:0] frame_o
);
  logic par;
  assign par = ^data_i;

  assign frame_o[0] = 1'b0;
  for (genvar i = 0; i < 8; i++) begin : g_bit
    assign frame_o[i+1] = inverse_i ? ~data_i[7-i] : data_i[i];
  end
  assign frame_o[FRAME_BITS-1] = inverse_i ? ~par : par;
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_tx_pkg::*;
#(
  parameter int ETU_CYCLES = 372,
  parameter int MAX_RETRY  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       card_tick_i,
  input  logic       clk_present_i,
  input  logic       card_present_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       inverse_i,
  input  logic       io_i,
  output logic       drive_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       fail_o
);
  localparam int RW = $clog2(MAX_RETRY + 1);
  localparam logic [SLOT_W-1:0] FRAME_LAST = SLOT_W'(FRAME_BITS - 1);
  localparam logic [SLOT_W-1:0] BACK_LAST  = SLOT_W'(BACKOFF_ETUS - 1);
  localparam logic [RW-1:0]     RETRY_MAX  = RW'(MAX_RETRY);

  tx_state_e             state_q;
  logic [SLOT_W-1:0]     slot_q;
  logic [RW-1:0]         retry_q;
  logic [FRAME_BITS-1:0] frame_q, frame_w;
  logic                  fail_q;
  logic                  etu_end;
  logic                  tmr_clr;

  assign tmr_clr = (state_q == ST_IDLE) || (state_q == ST_DONE);

  sc_etu_timer #(.ETU_CYCLES(ETU_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .tick_i    (card_tick_i),
    .etu_end_o (etu_end)
  );

  sc_frame_build u_build (
    .inverse_i (inverse_i),
    .data_i    (data_i),
    .frame_o   (frame_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      retry_q <= '0;
      frame_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (clk_present_i && card_present_i) begin
            state_q <= ST_SEND;
            slot_q  <= '0;
            retry_q <= '0;
            frame_q <= frame_w;
          end else begin
            state_q <= ST_DONE;
            fail_q  <= 1'b1;
          end
        end
        ST_SEND: if (etu_end) begin
          if (slot_q == FRAME_LAST) begin
            state_q <= ST_GUARD;
            slot_q  <= '0;
          end else begin
            slot_q  <= slot_q + 1'b1;
          end
        end
        ST_GUARD: if (etu_end) begin
          // low at end of guard ETU = receiver error signal
          if (!io_i && retry_q < RETRY_MAX) begin
            state_q <= ST_BACKOFF;
            retry_q <= retry_q + 1'b1;
            slot_q  <= '0;
          end else begin
            state_q <= ST_DONE;
            fail_q  <= !io_i;
          end
        end
        ST_BACKOFF: if (etu_end) begin
          if (slot_q == BACK_LAST) begin
            state_q <= ST_SEND;
            slot_q  <= '0;
          end else begin
            slot_q  <= slot_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_low_o = (state_q == ST_SEND) && !frame_q[slot_q];
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign fail_o      = fail_q;

  assert_no_drive_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_low_o |-> busy_o);
  assert_refuse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !(clk_present_i && card_present_i))
      |=> (done_o && fail_o && !drive_low_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_bit_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !etu_end) |=> $stable(drive_low_o));
  assert_ack_ok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GUARD && etu_end && io_i) |=> (done_o && !fail_o));
  assert_fail_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o && $past(state_q) == ST_GUARD) |-> (retry_q == RETRY_MAX));
endmodule

// File: tb/sc_char_tx_tb.sv
`timescale 1ns/1ps
module sc_char_tx_tb;
  localparam int ETU = 5;
  localparam int MR  = 4;
  localparam int ATT = 13 * ETU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, inv = 1'b0, tick = 1'b1;
  logic clk_ok = 1'b1, card_ok = 1'b1;
  logic [7:0] data = 8'h00;
  logic drive_low, busy, done, fail;
  logic rx_pull, io;
  bit   slow_tick = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_state = 0, m_tt = 0, m_end = 0, m_nack = 0, nack_cfg = 0;
  bit m_fail = 1'b0;
  logic [9:0] m_frame = '0;

  always #2.5 clk = ~clk;

  assign io = !(drive_low || rx_pull);

  sc_char_tx #(.ETU_CYCLES(ETU), .MAX_RETRY(MR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .card_tick_i(tick),
    .clk_present_i(clk_ok), .card_present_i(card_ok),
    .start_i(start), .data_i(data), .inverse_i(inv), .io_i(io),
    .drive_low_o(drive_low), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  function automatic logic [9:0] make_frame(logic [7:0] d, logic iv);
    logic [9:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = iv ? ~d[7-i] : d[i];
    f[9] = iv ? ~(^d) : (^d);
    return f;
  endfunction

  // receiver pulls low in the guard ETU of nacked attempts
  always_comb begin
    rx_pull = 1'b0;
    if (m_state == 1)
      rx_pull = (((m_tt % ATT) / ETU) == 10) && ((m_tt / ATT) < m_nack);
  end

  always @(posedge clk or negedge rst_n) begin
    int nt;
    int a;
    if (!rst_n) begin
      m_state <= 0; m_tt <= 0; m_fail <= 1'b0;
    end else begin
      case (m_state)
        0: if (start) begin
          if (clk_ok && card_ok) begin
            a = (nack_cfg < MR ? nack_cfg : MR) + 1;
            m_state <= 1; m_tt <= 0; m_nack <= nack_cfg;
            m_frame <= make_frame(data, inv);
            m_end   <= (a - 1) * ATT + 11 * ETU;
          end else begin
            m_state <= 2; m_fail <= 1'b1;
          end
        end
        1: if (tick) begin
          nt = m_tt + 1;
          m_tt <= nt;
          if (nt == m_end) begin
            m_state <= 2;
            m_fail  <= (m_nack > MR);
          end
        end
        default: m_state <= 0;
      endcase
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic e_drv;
    int slot;
    cyc++;
    tick <= slow_tick ? ((cyc % 3) == 0) : 1'b1;
    if (rst_n) begin
      slot  = (m_tt % ATT) / ETU;
      e_drv = (m_state == 1) && (slot < 10) && !m_frame[slot];
      check(drive_low, e_drv, cur_req, "line");
      check(busy, m_state != 0, "R10", "busy");
      check(done, m_state == 2, "R10", "done");
      check(fail, m_fail, (m_state == 2) ? cur_req : "R10", "fail");
    end
  end

  task automatic send(input logic [7:0] d, input logic iv, input int nacks, input string req);
    @(negedge clk);
    data = d; inv = iv; nack_cfg = nacks; cur_req = req; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_state != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_disturbed(input logic [7:0] d, input logic iv);
    @(negedge clk);
    data = d; inv = iv; nack_cfg = 1; cur_req = "R9"; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    data = ~d; inv = ~iv; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1; data = 8'h00;
    @(negedge clk);
    start = 1'b0;
    while (m_state != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(drive_low, 1'b0, "R1", "reset line");
    check(busy, 1'b0, "R1", "reset busy");
    check(done, 1'b0, "R1", "reset done");
    check(fail, 1'b0, "R1", "reset fail");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(8'hA5, 1'b0, 0, "R3");
    send(8'h01, 1'b0, 0, "R3");
    send(8'h3B, 1'b1, 0, "R4");
    send(8'hF0, 1'b1, 0, "R4");
    send(8'h6C, 1'b0, 0, "R5");
    send(8'h5A, 1'b0, 2, "R6");
    send(8'hC3, 1'b1, 1, "R6");
    send(8'h77, 1'b0, MR, "R7");
    send(8'h18, 1'b1, MR + 1, "R7");
    send(8'h99, 1'b0, 0, "R5");
    clk_ok = 1'b0;
    send(8'hFF, 1'b0, 0, "R8");
    clk_ok = 1'b1; card_ok = 1'b0;
    send(8'h00, 1'b1, 0, "R8");
    card_ok = 1'b1;
    send_disturbed(8'h2D, 1'b0);
    slow_tick = 1'b1;
    send(8'hB6, 1'b0, 1, "R2");
    send(8'h4E, 1'b1, 0, "R2");
    slow_tick = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule